// File: doc/BRIEF.md
# Peripheral Clock and Reset Sequencer

This block performs a safe reset of a peripheral. It drives a system controller through four write-one control pulses: clock enable, clock disable, reset assert and reset release. It watches two status levels that report the peripheral's reset state and clock state. When a start pulse arrives, the block runs four steps in a fixed order:

1. Put the peripheral into reset.
2. Stop its clock.
3. Take it out of reset.
4. Restart its clock.

After each pulse it polls the relevant status level until that level reaches the expected value. Each poll is bounded.

When the last step completes, the block signals done. If any poll runs out of time, the block stops at once, sets a sticky error flag, records which step failed and still signals done. The status levels come from another clock domain, so they pass through a two-flop synchronizer before they are compared.

Top module: `periph_rst_seq`

## Requirements
- R1: A start pulse accepted while idle produces a one-cycle reset-assert pulse on the following cycle. The step then waits until the synchronized reset status reads 1.
- R2: The second step pulses clock disable and waits for the synchronized clock status to read 0.
- R3: The third step pulses reset release and waits for the synchronized reset status to read 0.
- R4: The fourth step pulses clock enable and waits for the clock status to read 1. Done then follows with the error flag low. A clean run emits exactly four pulses, in step order.
- R5: Each wait lasts at most TIMEOUT cycles, and the counter reloads at every step. On expiry the block does the following:
  - it sets the error flag;
  - it loads fail_step with the step index (0 = reset assert, 1 = clock disable, 2 = reset release, 3 = clock enable);
  - it pulses done;
  - it emits no later control pulse.
- R6: Every control output is high for exactly one cycle at a time, and no two control outputs are high together.
- R7: Done is a single-cycle pulse after every run, whether the run succeeded or failed. busy is high from the cycle after an accepted start until done.
- R8: The error flag stays set until the next accepted start, which clears it together with fail_step.
- R9: A start pulse that arrives while busy is ignored. The run in progress still produces one done and one set of pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| rst_stat_i | input | 1 | Reset status from the system controller (asynchronous) |
| clk_stat_i | input | 1 | Clock status from the system controller (asynchronous) |
| rst_req_o | output | 1 | Reset-assert write-one pulse |
| clk_dis_o | output | 1 | Clock-disable write-one pulse |
| rst_rel_o | output | 1 | Reset-release write-one pulse |
| clk_en_o | output | 1 | Clock-enable write-one pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Sticky timeout error |
| fail_step_o | output | 2 | Index of the step that timed out |

## Verification
The bench drives the main function with a model of the system controller. The model can be set up in three ways:

- **Normal:** status follows each pulse after a short latency. This shows the full four-step ordering and the done timing.
- **Stuck step:** the model ignores the pulse of one chosen step. Each of the four choices is tried, which separates the failed-step index and shows that no later pulse appears.
- **Slow:** the status latency exceeds the poll bound, which tells a bounded wait apart from an unbounded one.

Two further patterns are tried:

- A second start during a run shows that the extra request is dropped.
- A success run after a failure shows that the error flag stays set and is then cleared.

// File: rtl/periph_rst_seq.sv
module periph_rst_seq #(
  parameter int unsigned TIMEOUT = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       rst_stat_i,
  input  logic       clk_stat_i,
  output logic       rst_req_o,
  output logic       clk_dis_o,
  output logic       rst_rel_o,
  output logic       clk_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [1:0] fail_step_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_WAIT} state_t;

  state_t        state;
  logic [1:0]    step;
  logic [CW-1:0] cnt;
  logic [1:0]    rs_q, cs_q;
  logic          met, pulse_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs_q <= '0;
      cs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], rst_stat_i};
      cs_q <= {cs_q[0], clk_stat_i};
    end

  // even steps watch reset status, odd steps watch clock status
  assign met      = step[0] ? (cs_q[1] == step[1]) : (rs_q[1] == ~step[1]);
  assign pulse_on = (state == S_PULSE);
  assign rst_req_o = pulse_on && step == 2'd0;
  assign clk_dis_o = pulse_on && step == 2'd1;
  assign rst_rel_o = pulse_on && step == 2'd2;
  assign clk_en_o  = pulse_on && step == 2'd3;
  assign busy_o    = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= S_IDLE;
      step        <= 2'd0;
      cnt         <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      fail_step_o <= 2'd0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE:
          if (start_i) begin
            state       <= S_PULSE;
            step        <= 2'd0;
            err_o       <= 1'b0;
            fail_step_o <= 2'd0;
          end
        S_PULSE: begin
          state <= S_WAIT;
          cnt   <= CW'(TIMEOUT);
        end
        S_WAIT:
          if (met) begin
            if (step == 2'd3) begin
              state  <= S_IDLE;
              done_o <= 1'b1;
            end else begin
              step  <= step + 2'd1;
              state <= S_PULSE;
            end
          end else if (cnt <= CW'(1)) begin
            state       <= S_IDLE;
            done_o      <= 1'b1;
            err_o       <= 1'b1;
            fail_step_o <= step;
          end else begin
            cnt <= cnt - CW'(1);
          end
        default: state <= S_IDLE;
      endcase
    end

  AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(state == S_IDLE && start_i)); // R1
  AST_DIS_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !clk_dis_o); // R2
  AST_ONE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rst_req_o, clk_dis_o, rst_rel_o, clk_en_o}) <= 1); // R6
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o || clk_dis_o || rst_rel_o || clk_en_o)
      |=> !(rst_req_o || clk_dis_o || rst_rel_o || clk_en_o)); // R6
  AST_DONE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !(state == S_IDLE && start_i)) |=> err_o); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_WAIT |-> (cnt >= CW'(1) && cnt <= CW'(TIMEOUT))); // R5
  AST_NO_PULSE_IDLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && err_o && !start_i) |=> !rst_req_o && !clk_en_o); // R5
endmodule

// File: tb/sim_periph_rst_seq.sv
module sim_periph_rst_seq;
  localparam int TMO = 32;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic rs = 1'b0, cs = 1'b1;
  logic rst_req_o, clk_dis_o, rst_rel_o, clk_en_o, busy_o, done_o, err_o;
  logic [1:0] fail_step_o;

  int checks = 0, fails = 0;
  int lat = 3, fault = 4;
  int pcnt = 0, base = 0;
  bit order_bad = 0;
  bit pend = 0;
  int pend_kind = 0, pend_cnt = 0;
  logic [5:0] expq[$];

  always #2 clk = ~clk;

  periph_rst_seq #(.TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rst_stat_i(rs), .clk_stat_i(cs),
    .rst_req_o(rst_req_o), .clk_dis_o(clk_dis_o), .rst_rel_o(rst_rel_o),
    .clk_en_o(clk_en_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .fail_step_o(fail_step_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // system controller model and result monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        if (pend_cnt == 0) begin
          case (pend_kind)
            0: rs = 1'b1;
            1: cs = 1'b0;
            2: rs = 1'b0;
            default: cs = 1'b1;
          endcase
          pend = 0;
        end else pend_cnt--;
      end
      begin
        int j;
        j = rst_req_o ? 0 : clk_dis_o ? 1 : rst_rel_o ? 2 : clk_en_o ? 3 : -1;
        if (j >= 0) begin
          if (j != pcnt - base) order_bad = 1;
          pcnt++;
          if (j != fault) begin
            pend = 1; pend_kind = j; pend_cnt = lat;
          end
        end
      end
      if (done_o) begin
        logic [5:0] e;
        if (expq.size() == 0) chk(0, "R7 unexpected done", 1, 0);
        else begin
          e = expq.pop_front();
          chk(err_o == e[5], "R5/R4 err", err_o, e[5]);
          chk(fail_step_o == e[4:3], "R5 fail_step", fail_step_o, e[4:3]);
          chk(pcnt - base == e[2:0], "R5/R4 pulse count", pcnt - base, e[2:0]);
          chk(!order_bad, "R1 R2 R3 R4 pulse order", order_bad, 0);
        end
        order_bad = 0;
        base = pcnt;
      end
    end
  end

  task automatic run(input int l, input int f, input bit dup);
    logic [5:0] e;
    lat = l; fault = f;
    if (f < 4) e = {1'b1, 2'(f), 3'(f + 1)};
    else if (l > TMO) e = {1'b1, 2'd0, 3'd1};
    else e = {1'b0, 2'd0, 3'd4};
    expq.push_back(e);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(rst_req_o == 1'b1, "R1 reset pulse after start", rst_req_o, 1);
    chk(busy_o == 1'b1 && err_o == 1'b0, "R7 R8 busy/err after start", {busy_o, err_o}, 2);
    if (dup) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (expq.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({rst_req_o, clk_dis_o, rst_rel_o, clk_en_o, busy_o, done_o, err_o} == 0,
        "R6 reset state", 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run(3, 4, 0);                                       // R4 clean run
    repeat (4) @(negedge clk);
    for (int f = 0; f < 4; f++) begin
      run(2, f, 0);                                     // R5 stuck step f
      repeat (10) @(negedge clk);
      chk(err_o == 1'b1 && !busy_o, "R8 err sticky", err_o, 1);
      chk(fail_step_o == 2'(f), "R5 fail_step held", fail_step_o, f);
      run(1, 4, 0);                                     // R8 cleared by next run
      repeat (4) @(negedge clk);
      chk(err_o == 1'b0, "R8 err cleared", err_o, 0);
    end
    run(TMO + 8, 4, 0);                                 // R5 slow status times out
    repeat (TMO + 20) @(negedge clk);
    run(0, 4, 0);                                       // R3 recovers from leftover status
    repeat (4) @(negedge clk);
    run(4, 4, 1);                                       // R9 start while busy
    repeat (12) @(negedge clk);
    chk(busy_o == 1'b0 && expq.size() == 0, "R9 no extra run", busy_o, 0);
    chk(pcnt == base, "R9 no extra pulses", pcnt - base, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule